// File: doc/BRIEF.md
# Half-Precision Floating-Point Adder

This block adds or subtracts two 16-bit binary floating-point numbers. Each number has a sign bit, a 5-bit biased exponent (bias 15) and a 10-bit fraction. The operation select flips the sign of the second operand, so one datapath serves both add and subtract. Normal operands get their hidden leading one back. Denormals keep a zero leading bit and use the smallest normal exponent.

The smaller operand is shifted right to line up with the larger one. Three extra bits below the last fraction bit hold the guard, the round and a sticky OR of everything shifted further. The significands are then added or subtracted. The result is normalised right by one place after a carry, or left by as many places as cancellation needs, but never below the smallest normal exponent. It is then rounded, renormalised if rounding carried out, and packed without the hidden bit.

A one-bit mode input selects round-to-nearest-even or truncation toward zero. Zeros, infinities, NaNs and denormals are decoded in full. The result and two flags, overflow and underflow, are registered. They appear one clock after the input strobe, together with an output valid.

Top module: `hpa_adder`

## Requirements
- R1: For finite operands with rnd_mode=0, result is the exact sum rounded to the nearest representable half value, and packed as sign in bit 15, exponent field in bits 14:10 and fraction in bits 9:0.
- R2: When the exact sum lies halfway between two representable values, rnd_mode=0 picks the one with an even last fraction bit. Bits shifted out during alignment, however far, still count toward rounding.
- R3: Subtraction that cancels leading bits renormalises the result left with the exponent adjusted. An exactly zero result is +0 (0x0000), except that the sum of two negative zeros is -0 (0x8000).
- R4: Denormal operands (exponent field 0) take part with no hidden one. A nonzero result too small for a normal number is returned as a denormal and sets unf. unf is otherwise 0.
- R5: A finite result whose rounded exponent would reach 31 sets ovf. The result is ±infinity (0x7C00 with the sign) when rnd_mode=0, and the largest finite value (0x7BFF with the sign) when rnd_mode=1.
- R6: With rnd_mode=1 the exact sum is truncated toward zero; bits below the last fraction bit are dropped.
- R7: If either operand is a NaN (exponent 31, fraction nonzero), or infinities of opposite effective sign are added, the result is 0x7E00 with ovf=0 and unf=0.
- R8: An infinity combined with a finite operand, or with an infinity of the same effective sign, returns that infinity with flags clear.
- R9: out_valid is high exactly one clock after a cycle with in_valid high, and result/ovf/unf belong to that input. During reset out_valid, result, ovf and unf are 0.
- R10: op_sub=1 computes op_a minus op_b by inverting op_b's sign before the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| op_sub | input | 1 | 1 = subtract op_b from op_a |
| rnd_mode | input | 1 | 0 = nearest-even, 1 = toward zero |
| out_valid | output | 1 | Result registered from the previous valid input |
| result | output | 16 | Rounded sum or difference |
| ovf | output | 1 | Finite operands produced an out-of-range result |
| unf | output | 1 | Result is a nonzero denormal |

## Verification
The datapath has no state beyond the output register. Any wrong alignment shift, sticky capture, normalisation count or rounding decision therefore appears in the very next result word. It shows most often as an error of one unit in the last place on tie cases, or as a wrong exponent after deep cancellation. A wrong special-value decode shows up the same cycle as a non-canonical NaN, a finite value where an infinity was due, or a flag set with an incompatible encoding. A broken valid path appears as a result with no matching request, or a request that never completes.

// File: rtl/hpa_pkg.sv
package hpa_pkg;
  localparam int DEF_EW    = 5;
  localparam int DEF_FW    = 10;
  localparam int GRS_BITS  = 3;

  typedef enum logic {
    RND_NEAREST_EVEN = 1'b0,
    RND_TOWARD_ZERO  = 1'b1
  } rnd_mode_e;
endpackage

// File: rtl/hpa_unpack.sv
module hpa_unpack #(
  parameter int EW = hpa_pkg::DEF_EW,
  parameter int FW = hpa_pkg::DEF_FW
) (
  input  logic [EW+FW:0] word,
  output logic           sign,
  output logic           is_nan,
  output logic           is_inf,
  output logic [EW-1:0]  exp_eff,
  output logic [FW:0]    sig
);
  logic [EW-1:0] efield;
  logic [FW-1:0] ffield;

  always_comb begin
    sign    = word[EW+FW];
    efield  = word[EW+FW-1:FW];
    ffield  = word[FW-1:0];
    is_nan  = (&efield) && (|ffield);
    is_inf  = (&efield) && !(|ffield);
    // denormals live at the smallest normal exponent without a hidden one
    exp_eff = (efield == '0) ? EW'(1) : efield;
    sig     = {(efield != '0), ffield};
  end
endmodule

// File: rtl/hpa_align_add.sv
module hpa_align_add #(
  parameter int EW = hpa_pkg::DEF_EW,
  parameter int FW = hpa_pkg::DEF_FW,
  localparam int GB = hpa_pkg::GRS_BITS,
  localparam int XW = FW + 1 + GB
) (
  input  logic          sa,
  input  logic [EW-1:0] ea,
  input  logic [FW:0]   ma,
  input  logic          sb,
  input  logic [EW-1:0] eb,
  input  logic [FW:0]   mb,
  output logic          sign_big,
  output logic [EW-1:0] exp_big,
  output logic [XW:0]   sum
);
  localparam logic [EW-1:0] XW_E = EW'(XW);

  logic          a_big;
  logic [FW:0]   sig_big, sig_sml;
  logic [EW-1:0] exp_sml, diff, sh;
  logic [XW-1:0] full, mask, aligned;
  logic          lost;

  always_comb begin
    a_big    = {ea, ma} >= {eb, mb};
    sign_big = a_big ? sa : sb;
    exp_big  = a_big ? ea : eb;
    exp_sml  = a_big ? eb : ea;
    sig_big  = a_big ? ma : mb;
    sig_sml  = a_big ? mb : ma;
    diff     = exp_big - exp_sml;
    sh       = (diff > XW_E) ? XW_E : diff;
    full     = {sig_sml, {GB{1'b0}}};
    mask     = (XW'(1) << sh) - XW'(1);
    lost     = |(full & mask);
    aligned  = (full >> sh) | XW'(lost);
    if (sa ^ sb)
      sum = {1'b0, sig_big, {GB{1'b0}}} - {1'b0, aligned};
    else
      sum = {1'b0, sig_big, {GB{1'b0}}} + {1'b0, aligned};
  end
endmodule

// File: rtl/hpa_norm_round.sv
module hpa_norm_round #(
  parameter int EW = hpa_pkg::DEF_EW,
  parameter int FW = hpa_pkg::DEF_FW,
  localparam int GB  = hpa_pkg::GRS_BITS,
  localparam int SW  = FW + 1,
  localparam int XW  = SW + GB,
  localparam int EXW = EW + 2
) (
  input  logic                 sign,
  input  logic [EW-1:0]        exp_in,
  input  logic [XW:0]          sum,
  input  hpa_pkg::rnd_mode_e   mode,
  output logic                 zero,
  output logic [EW+FW:0]       word,
  output logic                 ovf,
  output logic                 unf
);
  localparam logic [EXW-1:0] EMAX = EXW'((1 << EW) - 1);

  logic [EXW-1:0] exp_w, exp_n, exp_f, lz, lim, sh;
  logic [XW-1:0]  nrm;
  logic           lsb, grd, stk, up;
  logic [SW:0]    rnd;
  logic [SW-1:0]  mant;

  always_comb begin
    zero  = (sum == '0);
    exp_w = EXW'(exp_in);
    lz    = EXW'(XW);
    for (int i = 0; i < XW; i++)
      if (sum[i]) lz = EXW'(XW - 1 - i);
    lim   = exp_w - EXW'(1);
    sh    = (lz < lim) ? lz : lim;
    if (sum[XW]) begin
      nrm   = {sum[XW:2], sum[1] | sum[0]};
      exp_n = exp_w + EXW'(1);
    end else begin
      nrm   = sum[XW-1:0] << sh;
      exp_n = exp_w - sh;
    end
    lsb  = nrm[GB];
    grd  = nrm[GB-1];
    stk  = |nrm[GB-2:0];
    up   = (mode == hpa_pkg::RND_NEAREST_EVEN) && grd && (stk || lsb);
    rnd  = {1'b0, nrm[XW-1:GB]} + {{SW{1'b0}}, up};
    if (rnd[SW]) begin
      mant  = rnd[SW:1];
      exp_f = exp_n + EXW'(1);
    end else begin
      mant  = rnd[SW-1:0];
      exp_f = exp_n;
    end
    ovf = 1'b0;
    unf = 1'b0;
    if (exp_f >= EMAX) begin
      ovf = 1'b1;
      if (mode == hpa_pkg::RND_NEAREST_EVEN)
        word = {sign, {EW{1'b1}}, {FW{1'b0}}};
      else
        word = {sign, {(EW-1){1'b1}}, 1'b0, {FW{1'b1}}};
    end else begin
      word = {sign, (mant[FW] ? exp_f[EW-1:0] : {EW{1'b0}}), mant[FW-1:0]};
      unf  = !mant[FW] && !zero;
    end
  end
endmodule

// File: rtl/hpa_adder.sv
module hpa_adder #(
  parameter int EW = hpa_pkg::DEF_EW,
  parameter int FW = hpa_pkg::DEF_FW,
  localparam int WW = 1 + EW + FW,
  localparam int XW = FW + 1 + hpa_pkg::GRS_BITS
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [WW-1:0] op_a,
  input  logic [WW-1:0] op_b,
  input  logic          op_sub,
  input  logic          rnd_mode,
  output logic          out_valid,
  output logic [WW-1:0] result,
  output logic          ovf,
  output logic          unf
);
  localparam logic [WW-1:0] QNAN = {1'b0, {EW{1'b1}}, 1'b1, {(FW-1){1'b0}}};

  logic [WW-1:0] opw [2];
  logic          sgn [2];
  logic          nan [2];
  logic          inf [2];
  logic [EW-1:0] eex [2];
  logic [FW:0]   sig [2];

  assign opw[0] = op_a;
  assign opw[1] = op_b;

  for (genvar g = 0; g < 2; g++) begin : g_unpack
    hpa_unpack #(.EW(EW), .FW(FW)) u_unpack (
      .word(opw[g]), .sign(sgn[g]), .is_nan(nan[g]), .is_inf(inf[g]),
      .exp_eff(eex[g]), .sig(sig[g])
    );
  end

  logic          sb_eff, sign_big, nr_zero, nr_ovf, nr_unf;
  logic [EW-1:0] exp_big;
  logic [XW:0]   sum;
  logic [WW-1:0] nr_word, nxt_res;
  logic          nxt_ovf, nxt_unf;
  hpa_pkg::rnd_mode_e mode_e;

  assign sb_eff = sgn[1] ^ op_sub;
  assign mode_e = hpa_pkg::rnd_mode_e'(rnd_mode);

  hpa_align_add #(.EW(EW), .FW(FW)) u_align (
    .sa(sgn[0]), .ea(eex[0]), .ma(sig[0]),
    .sb(sb_eff), .eb(eex[1]), .mb(sig[1]),
    .sign_big(sign_big), .exp_big(exp_big), .sum(sum)
  );

  hpa_norm_round #(.EW(EW), .FW(FW)) u_norm (
    .sign(sign_big), .exp_in(exp_big), .sum(sum), .mode(mode_e),
    .zero(nr_zero), .word(nr_word), .ovf(nr_ovf), .unf(nr_unf)
  );

  always_comb begin
    nxt_ovf = 1'b0;
    nxt_unf = 1'b0;
    if (nan[0] || nan[1] || (inf[0] && inf[1] && (sgn[0] != sb_eff)))
      nxt_res = QNAN;
    else if (inf[0])
      nxt_res = {sgn[0], {EW{1'b1}}, {FW{1'b0}}};
    else if (inf[1])
      nxt_res = {sb_eff, {EW{1'b1}}, {FW{1'b0}}};
    else if (nr_zero)
      nxt_res = {sgn[0] & sb_eff, {(WW-1){1'b0}}};
    else begin
      nxt_res = nr_word;
      nxt_ovf = nr_ovf;
      nxt_unf = nr_unf;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      ovf       <= 1'b0;
      unf       <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= nxt_res;
        ovf    <= nxt_ovf;
        unf    <= nxt_unf;
      end
    end
  end
endmodule

// File: rtl/hpa_adder_chk.sv
module hpa_adder_chk #(
  parameter int EW = hpa_pkg::DEF_EW,
  parameter int FW = hpa_pkg::DEF_FW
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [EW+FW:0] op_a,
  input logic [EW+FW:0] op_b,
  input logic          op_sub,
  input logic          out_valid,
  input logic [EW+FW:0] result,
  input logic          ovf,
  input logic          unf
);
  localparam int WW = 1 + EW + FW;
  localparam logic [WW-1:0] QNAN = {1'b0, {EW{1'b1}}, 1'b1, {(FW-1){1'b0}}};

  logic a_nan, b_nan, a_inf, b_fin, a_fin;
  assign a_nan = (&op_a[WW-2:FW]) && (|op_a[FW-1:0]);
  assign b_nan = (&op_b[WW-2:FW]) && (|op_b[FW-1:0]);
  assign a_inf = (&op_a[WW-2:FW]) && !(|op_a[FW-1:0]);
  assign a_fin = !(&op_a[WW-2:FW]);
  assign b_fin = !(&op_b[WW-2:FW]);

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R9
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R9
  AST_NAN_CANON: assert property (@(posedge clk) disable iff (rst)
    in_valid && (a_nan || b_nan) |=> (result == QNAN) && !ovf && !unf); // R7
  AST_INF_WITH_FINITE: assert property (@(posedge clk) disable iff (rst)
    in_valid && a_inf && b_fin |=>
      (result == {$past(op_a[WW-1]), {EW{1'b1}}, {FW{1'b0}}}) && !ovf && !unf); // R8
  AST_SELF_SUB_ZERO: assert property (@(posedge clk) disable iff (rst)
    in_valid && op_sub && a_fin && (op_a == op_b) |=> result == '0); // R3
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !(ovf && unf)); // R5
  AST_OVF_ENCODING: assert property (@(posedge clk) disable iff (rst)
    out_valid && ovf |-> (result[WW-2:0] == {{EW{1'b1}}, {FW{1'b0}}}) ||
                         (result[WW-2:0] == {{(EW-1){1'b1}}, 1'b0, {FW{1'b1}}})); // R5
  AST_UNF_ENCODING: assert property (@(posedge clk) disable iff (rst)
    out_valid && unf |-> (result[WW-2:FW] == '0) && (result[FW-1:0] != '0)); // R4
endmodule

bind hpa_adder hpa_adder_chk #(.EW(EW), .FW(FW)) u_chk (.*);

// File: tb/tb_hpa_adder.sv
module tb_hpa_adder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] op_a = '0, op_b = '0;
  logic        op_sub = 1'b0, rnd_mode = 1'b0;
  logic        out_valid, ovf, unf;
  logic [15:0] result;

  int errs = 0, checks = 0;
  bit done = 0;

  typedef struct {
    logic [15:0] a, b, res;
    logic        ovf, unf;
    string       tag;
  } item_t;
  item_t sbq[$];

  always #2 clk = ~clk;

  hpa_adder dut (.clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
                 .op_sub(op_sub), .rnd_mode(rnd_mode), .out_valid(out_valid),
                 .result(result), .ovf(ovf), .unf(unf));

  // exact value in units of 2^-24
  function automatic longint mag_of(input logic [15:0] x);
    if (x[14:10] == 0) return longint'(x[9:0]);
    return longint'(1024 + x[9:0]) <<< (x[14:10] - 1);
  endfunction

  function automatic logic [17:0] ref_add(input logic [15:0] a, input logic [15:0] b,
                                          input logic sub, input logic md);
    logic sa, sb, sgn;
    longint s, m, keep, rem, half;
    int p, shift, field;
    sa = a[15]; sb = b[15] ^ sub;
    if ((a[14:10] == 31 && a[9:0] != 0) || (b[14:10] == 31 && b[9:0] != 0))
      return {2'b00, 16'h7E00};
    if (a[14:10] == 31 && b[14:10] == 31)
      return (sa != sb) ? {2'b00, 16'h7E00} : {2'b00, sa, 15'h7C00};
    if (a[14:10] == 31) return {2'b00, sa, 15'h7C00};
    if (b[14:10] == 31) return {2'b00, sb, 15'h7C00};
    s = (sa ? -mag_of(a) : mag_of(a)) + (sb ? -mag_of(b) : mag_of(b));
    if (s == 0) return {2'b00, sa & sb, 15'h0000};
    sgn = (s < 0);
    m = sgn ? -s : s;
    p = 0;
    for (int i = 0; i < 48; i++) if (m[i]) p = i;
    if (p <= 10) begin
      if (m >= 1024) return {2'b00, sgn, 5'd1, m[9:0]};
      return {2'b01, sgn, 5'd0, m[9:0]};
    end
    shift = p - 10;
    keep = m >>> shift;
    rem  = m & ((64'sd1 <<< shift) - 1);
    half = 64'sd1 <<< (shift - 1);
    if (!md && (rem > half || (rem == half && keep[0]))) keep = keep + 1;
    if (keep == 2048) begin keep = 1024; shift = shift + 1; end
    field = shift + 1;
    if (field >= 31) return md ? {2'b10, sgn, 15'h7BFF} : {2'b10, sgn, 15'h7C00};
    return {2'b00, sgn, field[4:0], keep[9:0]};
  endfunction

  task automatic send(input logic [15:0] a, input logic [15:0] b, input logic sub,
                      input logic md, input string tag);
    item_t it;
    logic [17:0] r;
    r = ref_add(a, b, sub, md);
    it.a = a; it.b = b; it.res = r[15:0]; it.ovf = r[17]; it.unf = r[16]; it.tag = tag;
    @(negedge clk);
    op_a = a; op_b = b; op_sub = sub; rnd_mode = md; in_valid = 1'b1;
    sbq.push_back(it);
  endtask

  // monitor: compare every valid output against the head of the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && out_valid) begin
        checks++;
        if (sbq.size() == 0) begin
          errs++;
          $display("FAIL R9 unexpected out_valid: got result=%h, expected no output", result);
        end else begin
          item_t e;
          e = sbq.pop_front();
          if (result !== e.res || ovf !== e.ovf || unf !== e.unf) begin
            errs++;
            $display("FAIL %s a=%h b=%h: got %h ovf=%b unf=%b, expected %h ovf=%b unf=%b",
                     e.tag, e.a, e.b, result, ovf, unf, e.res, e.ovf, e.unf);
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: got no completion, expected end of run");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || result !== 16'h0 || ovf !== 1'b0 || unf !== 1'b0) begin
      errs++;
      $display("FAIL R9 reset: got v=%b res=%h ovf=%b unf=%b, expected all zero",
               out_valid, result, ovf, unf);
    end
    rst = 1'b0;

    send(16'h3C00, 16'h3C00, 0, 0, "R1 1+1");
    send(16'h4248, 16'hC0A0, 0, 0, "R1 mixed signs");
    send(16'h3C00, 16'h1000, 0, 0, "R2 tie to even down");
    send(16'h3C01, 16'h1000, 0, 0, "R2 tie to even up");
    send(16'h3C00, 16'h0001, 0, 0, "R2 far sticky add");
    send(16'h3C00, 16'h0001, 1, 0, "R2 far sticky sub");
    send(16'h3C01, 16'h1000, 0, 1, "R6 truncate tie");
    send(16'h3C00, 16'h3BFF, 0, 1, "R6 truncate carry");
    send(16'h3800, 16'hB700, 0, 0, "R3 cancel add");
    send(16'h3C01, 16'h3C00, 1, 0, "R3 deep cancel");
    send(16'h4500, 16'h4500, 1, 0, "R3 exact zero");
    send(16'h8000, 16'h8000, 0, 0, "R3 neg zeros");
    send(16'h8000, 16'h0000, 1, 0, "R3 neg minus pos zero");
    send(16'h3800, 16'h3700, 1, 0, "R10 subtract select");
    send(16'h3C00, 16'hBC00, 1, 0, "R10 sub of negative");
    send(16'h0001, 16'h0001, 0, 0, "R4 denorm sum");
    send(16'h03FF, 16'h0001, 0, 0, "R4 denorm to normal");
    send(16'h0400, 16'h0001, 1, 0, "R4 normal to denorm");
    send(16'h0401, 16'h0400, 1, 0, "R4 cancel to denorm");
    send(16'h7BFF, 16'h7BFF, 0, 0, "R5 overflow inf");
    send(16'hFBFF, 16'hFBFF, 0, 1, "R5 overflow truncated");
    send(16'h7BFF, 16'h4C00, 0, 0, "R5 round into overflow");
    send(16'h7E01, 16'h3C00, 0, 0, "R7 nan a");
    send(16'h3C00, 16'hFC01, 0, 0, "R7 nan b");
    send(16'h7C00, 16'h7C00, 1, 0, "R7 inf minus inf");
    send(16'h7C00, 16'hFC00, 0, 0, "R7 inf plus neg inf");
    send(16'h7C00, 16'h3C00, 0, 0, "R8 inf plus finite");
    send(16'h3C00, 16'h7C00, 1, 0, "R8 finite minus inf");
    send(16'hFC00, 16'hFC00, 0, 0, "R8 same inf");

    for (int k = 0; k < 4000; k++) begin
      logic [15:0] a, b;
      a = 16'($urandom);
      b = 16'($urandom);
      if (k % 3 == 0) b = {b[15], a[14:10], b[9:0]};
      if (k % 7 == 0) b = a ^ {11'h0, 5'($urandom)};
      send(a, b, 1'($urandom), 1'($urandom), "R1 random");
    end

    @(negedge clk);
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    checks++;
    if (sbq.size() != 0) begin
      errs++;
      $display("FAIL R9 pending results: got %0d left, expected 0", sbq.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule